// File: doc/BRIEF.md
# USB Device Address and Status Register Bank

This block is a small bank of byte-wide registers inside a USB device interface engine. Firmware reaches it through a simple register bus with a two-bit select, a write enable, write data and combinational read data. The bank holds the device address together with the remote-wakeup enable, one stall flag per endpoint, and a status/control byte whose flags are raised by pulses from the serial engine and lowered by firmware or by the next SETUP token.

The serial engine drives single-cycle event pulses: SETUP token, IN token, OUT token with its data length, successful IN completion, NAK sent, packet error (CRC, PID or incomplete token), FIFO access error and bus reset, plus a level that is high while a token is being handled. The bank drives the live device address used by the packet matcher, the stall flags, the remote-wakeup enable and a one-cycle NAK interrupt request. The live address can either follow a firmware write at once or wait until the host has completed an IN read, which matches the status stage of an address-assignment request.

Top module: `usbdev_regs`

## Requirements
- R1: After power-on reset the address register reads 0x00, the stall register reads 0x00, the status register reads 0x40 (with the token-active input low), the live address is 0 and the wakeup enable is 0.
- R2: Register select 0 is the address register: bit 0 is the remote-wakeup enable (driven on the wake output) and bits 7:1 are the 7-bit device address; it reads back exactly what was written.
- R3: Register select 1 is the stall register: bits 4:0 are per-endpoint stall flags, written by firmware and driven on the stall output; bits 7:5 always read 0. Select 3 reads 0x00.
- R4: A SETUP token clears all stall flags and the OUT flag one cycle later; this clear wins over a firmware stall write in the same cycle.
- R5: Register select 2 is the status register; its bit 0 is the auto-address control. While it is 0, a write to the address register updates the live address on the next clock edge.
- R6: While auto-address is 1, a write to the address register does not change the live address; the next successful IN completion loads the latest written address. A second write before that completion replaces the pending value, and a completion with nothing pending changes nothing.
- R7: Status bit 2 (OUT flag) sets on an OUT token with non-zero length and stays clear for a zero-length OUT; firmware clears it by writing 0.
- R8: Status bit 5 (packet error) and bit 1 (FIFO error) set on their hardware events and clear only by a firmware write of 0; a SETUP token leaves them set, and a hardware set in the same cycle as a firmware clear wins.
- R9: Status bit 3 (IN token) sets on an IN token and clears on a SETUP or OUT token; bit 4 (NAK sent) sets on a NAK-sent event and clears on the next SETUP, IN or OUT token. Firmware writes to both bits are ignored.
- R10: Status bit 6 is the inverse of the token-active input, registered one cycle; firmware writes to it are ignored.
- R11: Status bit 7 masks the NAK interrupt: with it 0, each NAK-sent event gives a one-cycle interrupt pulse on the next cycle; with it 1, no pulse.
- R12: A bus reset returns all three registers to their power-on values, forces the live address to 0 and drops any pending deferred address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| regSel | input | 2 | Register select: 0 address, 1 stall, 2 status |
| wrEn | input | 1 | Firmware write strobe |
| wrData | input | 8 | Firmware write data |
| rdData | output | 8 | Read data for the selected register |
| setupTok | input | 1 | SETUP token received pulse |
| inTok | input | 1 | IN token received pulse |
| outTok | input | 1 | OUT token received pulse |
| outLen | input | 11 | Data length of the OUT token, valid with outTok |
| inDoneOk | input | 1 | Host completed an IN read successfully |
| nakSent | input | 1 | Device sent a NAK pulse |
| pktErr | input | 1 | CRC, PID or incomplete-token error pulse |
| fifoErr | input | 1 | FIFO access error pulse |
| busReset | input | 1 | USB bus reset pulse |
| tokActive | input | 1 | High while a token is being handled |
| devAddr | output | 7 | Live device address |
| wakeEn | output | 1 | Remote-wakeup enable |
| stallMask | output | 5 | Per-endpoint stall flags |
| nakIrq | output | 1 | One-cycle NAK interrupt request |

## Verification
The hardest situation to reach from the ports is the deferred address update in its corner cases: a pending address replaced by a second write, a completion with nothing pending, and a bus reset that must discard the pending value so a later completion leaves the address at 0. The bench sweeps all 128 addresses in deferred mode, writing a decoy value and then the real one before each completion and checking that the live address stays put until the completion. Same-cycle collisions are reached by raising an event pulse in the very cycle that carries a firmware write, which shows that the hardware set or clear wins.

// File: rtl/usbdev_regs_pkg.sv
package usbdev_regs_pkg;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_STALL = 2'd1;
  localparam logic [1:0] SEL_STAT  = 2'd2;

  // Status byte bit positions (firmware decodes these)
  localparam int BIT_AUTO  = 0;
  localparam int BIT_FIFO  = 1;
  localparam int BIT_OUT   = 2;
  localparam int BIT_IN    = 3;
  localparam int BIT_NAK   = 4;
  localparam int BIT_CRC   = 5;
  localparam int BIT_IDLEN = 6;
  localparam int BIT_MASK  = 7;

  typedef struct packed {
    logic rstBank;     // bus reset: back to power-on values
    logic wrAddr;      // firmware writes address register
    logic wrStall;     // firmware writes stall register
    logic wrStat;      // firmware writes status register
    logic loadLiveNow; // live address takes write data now
    logic commitLive;  // live address takes stored address
    logic clrStall;    // setup token clears stall flags
    logic setOut;
    logic clrOut;
    logic setIn;
    logic clrIn;
    logic setNak;
    logic clrNak;
    logic setCrc;
    logic setFifo;
    logic nakPulse;    // raise interrupt next cycle
  } strobes_t;

  // Flag update: hardware set > hardware clear > firmware write
  function automatic logic nextFlag(input logic cur, input logic hwSet,
                                    input logic hwClr, input logic fwWr,
                                    input logic fwVal);
    if (hwSet)      return 1'b1;
    else if (hwClr) return 1'b0;
    else if (fwWr)  return fwVal;
    else            return cur;
  endfunction

endpackage

// File: rtl/usbdev_regs_ctrl.sv
module usbdev_regs_ctrl
  import usbdev_regs_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic             setupTok,
  input  logic             inTok,
  input  logic             outTok,
  input  logic [LEN_W-1:0] outLen,
  input  logic             inDoneOk,
  input  logic             nakSent,
  input  logic             pktErr,
  input  logic             fifoErr,
  input  logic             busReset,
  input  logic             autoSet,
  input  logic             nakMask,
  output strobes_t         str
);

  logic pending;
  logic wrAddrHit;
  logic outHasData;

  assign wrAddrHit  = wrEn && (regSel == SEL_ADDR);
  assign outHasData = |outLen;

  always_comb begin
    str             = '0;
    str.rstBank     = busReset;
    str.wrAddr      = wrAddrHit && !busReset;
    str.wrStall     = wrEn && (regSel == SEL_STALL) && !busReset;
    str.wrStat      = wrEn && (regSel == SEL_STAT) && !busReset;
    str.loadLiveNow = wrAddrHit && !autoSet && !busReset;
    str.commitLive  = inDoneOk && pending && !busReset;
    str.clrStall    = setupTok;
    str.setOut      = outTok && outHasData;
    str.clrOut      = setupTok;
    str.setIn       = inTok;
    str.clrIn       = setupTok || outTok;
    str.setNak      = nakSent;
    str.clrNak      = setupTok || inTok || outTok;
    str.setCrc      = pktErr;
    str.setFifo     = fifoErr;
    str.nakPulse    = nakSent && !nakMask;
  end

  // Deferred-address bookkeeping: a write in auto mode arms, completion commits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (busReset) begin
      pending <= 1'b0;
    end else if (wrAddrHit && autoSet) begin
      pending <= 1'b1;
    end else if (inDoneOk) begin
      pending <= 1'b0;
    end
  end

  assert_pending_drop_R12: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !pending);

  assert_pending_arm_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrAddrHit && autoSet && !busReset) |=> pending);

endmodule

// File: rtl/usbdev_regs_dp.sv
module usbdev_regs_dp
  import usbdev_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_EP = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  input  strobes_t          str,
  input  logic              tokActive,
  output logic [DATA_W-2:0] liveAddr,
  output logic              wakeBit,
  output logic [NUM_EP-1:0] stallReg,
  output logic              autoSet,
  output logic              nakMask,
  output logic              nakIrq,
  output logic [DATA_W-1:0] rdData
);

  localparam int ADDR_W = DATA_W - 1;

  logic [ADDR_W-1:0] addrField;
  logic fifoF, outF, inF, nakF, crcF, idleN;
  logic [DATA_W-1:0] statByte;

  // Address / wake register and live address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrField <= '0;
      wakeBit   <= 1'b0;
      liveAddr  <= '0;
    end else if (str.rstBank) begin
      addrField <= '0;
      wakeBit   <= 1'b0;
      liveAddr  <= '0;
    end else begin
      if (str.wrAddr) begin
        addrField <= wrData[DATA_W-1:1];
        wakeBit   <= wrData[0];
      end
      if (str.loadLiveNow)
        liveAddr <= wrData[DATA_W-1:1];
      else if (str.commitLive)
        liveAddr <= addrField;
    end
  end

  // Stall flags, one flop per endpoint
  for (genvar ep = 0; ep < NUM_EP; ep++) begin : g_stall
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stallReg[ep] <= 1'b0;
      else if (str.rstBank || str.clrStall)
        stallReg[ep] <= 1'b0;
      else if (str.wrStall)
        stallReg[ep] <= wrData[ep];
    end
  end

  // Status byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoSet <= 1'b0;
      fifoF   <= 1'b0;
      outF    <= 1'b0;
      inF     <= 1'b0;
      nakF    <= 1'b0;
      crcF    <= 1'b0;
      idleN   <= 1'b1;
      nakMask <= 1'b0;
      nakIrq  <= 1'b0;
    end else if (str.rstBank) begin
      autoSet <= 1'b0;
      fifoF   <= 1'b0;
      outF    <= 1'b0;
      inF     <= 1'b0;
      nakF    <= 1'b0;
      crcF    <= 1'b0;
      idleN   <= 1'b1;
      nakMask <= 1'b0;
      nakIrq  <= 1'b0;
    end else begin
      autoSet <= nextFlag(autoSet, 1'b0, 1'b0, str.wrStat, wrData[BIT_AUTO]);
      fifoF   <= nextFlag(fifoF, str.setFifo, 1'b0, str.wrStat, wrData[BIT_FIFO]);
      outF    <= nextFlag(outF, str.setOut, str.clrOut, str.wrStat, wrData[BIT_OUT]);
      inF     <= nextFlag(inF, str.setIn, str.clrIn, 1'b0, 1'b0);
      nakF    <= nextFlag(nakF, str.setNak, str.clrNak, 1'b0, 1'b0);
      crcF    <= nextFlag(crcF, str.setCrc, 1'b0, str.wrStat, wrData[BIT_CRC]);
      idleN   <= !tokActive;
      nakMask <= nextFlag(nakMask, 1'b0, 1'b0, str.wrStat, wrData[BIT_MASK]);
      nakIrq  <= str.nakPulse;
    end
  end

  always_comb begin
    statByte            = '0;
    statByte[BIT_AUTO]  = autoSet;
    statByte[BIT_FIFO]  = fifoF;
    statByte[BIT_OUT]   = outF;
    statByte[BIT_IN]    = inF;
    statByte[BIT_NAK]   = nakF;
    statByte[BIT_CRC]   = crcF;
    statByte[BIT_IDLEN] = idleN;
    statByte[BIT_MASK]  = nakMask;
  end

  always_comb begin
    case (regSel)
      SEL_ADDR:  rdData = {addrField, wakeBit};
      SEL_STALL: rdData = DATA_W'(stallReg);
      SEL_STAT:  rdData = statByte;
      default:   rdData = '0;
    endcase
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (crcF && !str.wrStat && !str.rstBank) |=> crcF);

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    (str.setCrc && !str.rstBank) |=> crcF);

  assert_in_ro_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!str.setIn && !str.rstBank && !inF) |=> !inF);

endmodule

// File: rtl/usbdev_regs.sv
module usbdev_regs
  import usbdev_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_EP = 5,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              setupTok,
  input  logic              inTok,
  input  logic              outTok,
  input  logic [LEN_W-1:0]  outLen,
  input  logic              inDoneOk,
  input  logic              nakSent,
  input  logic              pktErr,
  input  logic              fifoErr,
  input  logic              busReset,
  input  logic              tokActive,
  output logic [DATA_W-2:0] devAddr,
  output logic              wakeEn,
  output logic [NUM_EP-1:0] stallMask,
  output logic              nakIrq
);

  strobes_t str;
  logic autoSet;
  logic nakMask;

  usbdev_regs_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn),
    .setupTok(setupTok), .inTok(inTok), .outTok(outTok), .outLen(outLen),
    .inDoneOk(inDoneOk), .nakSent(nakSent), .pktErr(pktErr),
    .fifoErr(fifoErr), .busReset(busReset), .autoSet(autoSet),
    .nakMask(nakMask), .str(str)
  );

  usbdev_regs_dp #(.DATA_W(DATA_W), .NUM_EP(NUM_EP)) u_dp (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrData(wrData), .str(str),
    .tokActive(tokActive), .liveAddr(devAddr), .wakeBit(wakeEn),
    .stallReg(stallMask), .autoSet(autoSet), .nakMask(nakMask),
    .nakIrq(nakIrq), .rdData(rdData)
  );

  assert_live_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devAddr) |-> ($past(busReset) || $past(inDoneOk) ||
                           ($past(wrEn) && $past(regSel) == SEL_ADDR)));

  assert_stall_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (setupTok || busReset) |=> (stallMask == '0));

  assert_nak_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (nakSent && !nakMask && !busReset) |=> nakIrq);

  assert_nak_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    nakIrq |-> $past(nakSent));

  assert_reset_live_R12: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (devAddr == '0 && !wakeEn));

endmodule

// File: tb/sim_usbdev_regs.sv
module sim_usbdev_regs;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regSel = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic setupTok = 0, inTok = 0, outTok = 0, inDoneOk = 0, nakSent = 0;
  logic pktErr = 0, fifoErr = 0, busReset = 0, tokActive = 0;
  logic [10:0] outLen = '0;
  logic [6:0] devAddr;
  logic wakeEn;
  logic [4:0] stallMask;
  logic nakIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  usbdev_regs u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .setupTok(setupTok), .inTok(inTok), .outTok(outTok),
    .outLen(outLen), .inDoneOk(inDoneOk), .nakSent(nakSent), .pktErr(pktErr),
    .fifoErr(fifoErr), .busReset(busReset), .tokActive(tokActive),
    .devAddr(devAddr), .wakeEn(wakeEn), .stallMask(stallMask), .nakIrq(nakIrq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    regSel = s; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    regSel = s;
    #1;
    v = rdData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [6:0] prev;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1: power-on values
    rd(2'd0, v); chk("R1 addr reg", v, 8'h00);
    rd(2'd1, v); chk("R1 stall reg", v, 8'h00);
    rd(2'd2, v); chk("R1 status reg", v, 8'h40);
    chk("R1 live addr", devAddr, 0);
    chk("R1 wake", wakeEn, 0);

    // R2 / R5: every address and wake value, immediate update
    for (int a = 0; a < 128; a++) begin
      for (int w = 0; w < 2; w++) begin
        wr(2'd0, 8'((a << 1) | w));
        chk("R5 live addr immediate", devAddr, a);
        chk("R2 wake output", wakeEn, w);
        rd(2'd0, v); chk("R2 readback", v, (a << 1) | w);
      end
    end

    // R3: every stall write value; upper bits read zero
    for (int s = 0; s < 256; s++) begin
      wr(2'd1, 8'(s));
      rd(2'd1, v); chk("R3 stall readback", v, s & 8'h1f);
      chk("R3 stall output", stallMask, s & 5'h1f);
    end
    rd(2'd3, v); chk("R3 unused select", v, 0);

    // R4: setup clears stall and OUT flag, also over a same-cycle write
    wr(2'd1, 8'h1f);
    outTok = 1; outLen = 11'd5; tick(); outTok = 0;
    rd(2'd2, v); chk("R7 out set", v[2], 1);
    setupTok = 1; tick(); setupTok = 0;
    chk("R4 stall cleared", stallMask, 0);
    rd(2'd2, v); chk("R4 out cleared by setup", v[2], 0);
    setupTok = 1; wr(2'd1, 8'h1f); setupTok = 0;
    chk("R4 setup beats write", stallMask, 0);

    // R6: deferred mode, full address sweep with replacement
    wr(2'd2, 8'h01);
    prev = devAddr;
    for (int a = 0; a < 128; a++) begin
      wr(2'd0, 8'(((a ^ 8'h55) & 8'h7f) << 1));
      chk("R6 hold after first write", devAddr, prev);
      wr(2'd0, 8'(a << 1));
      chk("R6 hold after replacement", devAddr, prev);
      inDoneOk = 1; tick(); inDoneOk = 0;
      chk("R6 commit on IN done", devAddr, a);
      prev = 7'(a);
    end
    wr(2'd0, 8'h10);
    chk("R6 hold", devAddr, prev);
    inDoneOk = 1; tick(); inDoneOk = 0;
    chk("R6 commit 0x08", devAddr, 8'h08);
    inDoneOk = 1; tick(); inDoneOk = 0;
    chk("R6 no pending no change", devAddr, 8'h08);
    wr(2'd2, 8'h00);

    // R7: zero-length OUT does not set, firmware clear
    outTok = 1; outLen = 11'd0; tick(); outTok = 0;
    rd(2'd2, v); chk("R7 zero length ignored", v[2], 0);
    outTok = 1; outLen = 11'd1; tick(); outTok = 0;
    rd(2'd2, v); chk("R7 out set len1", v[2], 1);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R7 fw clear", v[2], 0);

    // R8: error flags sticky across setup, hw set beats fw clear
    pktErr = 1; fifoErr = 1; tick(); pktErr = 0; fifoErr = 0;
    setupTok = 1; tick(); setupTok = 0;
    rd(2'd2, v); chk("R8 crc survives setup", v[5], 1);
    chk("R8 fifo survives setup", v[1], 1);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R8 fw clear", v & 8'h22, 0);
    pktErr = 1; fifoErr = 1; wr(2'd2, 8'h00); pktErr = 0; fifoErr = 0;
    rd(2'd2, v); chk("R8 hw set wins", v & 8'h22, 8'h22);
    wr(2'd2, 8'h00);

    // R9: IN and NAK bits read-only
    wr(2'd2, 8'h18);
    rd(2'd2, v); chk("R9 write cannot set", v & 8'h18, 0);
    inTok = 1; tick(); inTok = 0;
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R9 IN held over write", v[3], 1);
    outTok = 1; outLen = 0; tick(); outTok = 0;
    rd(2'd2, v); chk("R9 IN cleared by OUT", v[3], 0);
    nakSent = 1; tick(); nakSent = 0;
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R9 NAK held over write", v[4], 1);
    inTok = 1; tick(); inTok = 0;
    rd(2'd2, v); chk("R9 NAK cleared by token", v[4], 0);
    setupTok = 1; tick(); setupTok = 0;
    rd(2'd2, v); chk("R9 IN cleared by setup", v[3], 0);

    // R10: token-active mirror
    tokActive = 1; tick();
    rd(2'd2, v); chk("R10 active gives 0", v[6], 0);
    wr(2'd2, 8'h40);
    rd(2'd2, v); chk("R10 write ignored", v[6], 0);
    tokActive = 0; tick();
    rd(2'd2, v); chk("R10 idle gives 1", v[6], 1);

    // R11: NAK interrupt pulse and mask
    wr(2'd2, 8'h00);
    nakSent = 1; tick(); nakSent = 0;
    chk("R11 pulse", nakIrq, 1);
    tick();
    chk("R11 one cycle", nakIrq, 0);
    wr(2'd2, 8'h80);
    nakSent = 1; tick(); nakSent = 0;
    chk("R11 masked", nakIrq, 0);

    // R12: bus reset drops everything including pending address
    wr(2'd2, 8'h81);
    wr(2'd1, 8'h15);
    wr(2'd0, 8'hA5);
    pktErr = 1; tick(); pktErr = 0;
    chk("R12 precondition live", devAddr, 8'h08);
    busReset = 1; tick(); busReset = 0;
    rd(2'd0, v); chk("R12 addr reg", v, 0);
    rd(2'd1, v); chk("R12 stall reg", v, 0);
    rd(2'd2, v); chk("R12 status reg", v, 8'h40);
    chk("R12 live addr", devAddr, 0);
    chk("R12 wake", wakeEn, 0);
    inDoneOk = 1; tick(); inDoneOk = 0;
    chk("R12 pending dropped", devAddr, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule